// File: doc/BRIEF.md
# Per-VC Credit Flow Control Tracker

The tracker sits on an output port of an upstream router and mirrors how many free slots remain in each virtual channel of the downstream input buffer. It keeps one counter per VC and exposes a vector that says, for each VC, whether a flit may be launched right now. Launching a flit consumes one credit from the chosen VC. The downstream router returns a credit token, tagged with a VC, each time it frees a buffer slot.

Each returned credit goes through one register stage before it reaches the counter. This register models the credit processing delay. The default depth of six credits per VC covers a round trip of one cycle of data propagation, one cycle of credit propagation, one cycle of credit processing and a three-stage router pipeline. With that depth, a steady stream on one VC never stalls on backpressure.

The block also flags two protocol violations. A launch on a VC that has no credit leaves the count at zero. A credit that would raise a count above the buffer depth is dropped, and the count stays at the depth.

Top module: `vc_credit_tracker`

## Requirements
- R1: After reset every VC holds DEPTH credits, so every bit of `can_send` is 1 and both error outputs are 0.
- R2: A launch (`send_vld`=1) on a VC whose count is nonzero lowers that VC's count by one at the next clock edge and leaves every other VC unchanged.
- R3: A VC whose count is zero shows `can_send`=0. A launch on such a VC raises `send_err` in the same cycle, and the count stays at zero with no wrap.
- R4: A credit presented with `crd_vld`=1 in cycle t has no effect on `can_send` after the edge that ends cycle t. It is applied at the edge that ends cycle t+1.
- R5: An applied credit raises the count of the VC named in `crd_vc` by one and touches no other VC.
- R6: When an accepted launch and an applied credit name the same VC in the same cycle, that VC's count does not change.
- R7: When an applied credit would push a count above DEPTH, `crd_err` is 1 during the cycle the credit is applied and the count stays at DEPTH.
- R8: The VCs are independent. Draining one VC has no effect on whether a launch is allowed on any other VC.
- R9: With default parameters, DEPTH is 6. Exactly six back-to-back launches are accepted on a fresh VC before its `can_send` bit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_vld | input | 1 | A flit is being launched this cycle |
| send_vc | input | VW | VC of the launched flit |
| crd_vld | input | 1 | A credit token arrives this cycle |
| crd_vc | input | VW | VC named by the credit token |
| can_send | output | NUM_VC | Per-VC flag, 1 when at least one credit remains |
| send_err | output | 1 | Launch attempted on a VC with zero credits |
| crd_err | output | 1 | Applied credit would exceed DEPTH and was dropped |

## Verification
The properties assume that both VC id inputs name an existing VC. They also assume that `crd_vld` is held low during reset, so the credit register starts empty. The stimulus draws every VC id modulo NUM_VC and drives all inputs to zero while reset is asserted. Random traffic mixes launches and credits freely, so zero-credit launches happen naturally. Directed sequences add the overflowing credit, the same-VC coincidence and the delayed-credit timing.

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker #(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 6,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_vld,
  input  logic [VW-1:0]     send_vc,
  input  logic              crd_vld,
  input  logic [VW-1:0]     crd_vc,
  output logic [NUM_VC-1:0] can_send,
  output logic              send_err,
  output logic              crd_err
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic              pend_vld;
  logic [VW-1:0]     pend_vc;
  logic [NUM_VC-1:0] ovf;
  logic              send_ok;

  // credit processing stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_vc  <= '0;
    end else begin
      pend_vld <= crd_vld;
      pend_vc  <= crd_vc;
    end
  end

  assign send_ok  = send_vld & can_send[send_vc];
  assign send_err = send_vld & ~can_send[send_vc];
  assign crd_err  = |ovf;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CW-1:0] cnt;
    logic dec, inc, full;

    assign dec         = send_ok  && (send_vc == VW'(v));
    assign inc         = pend_vld && (pend_vc == VW'(v));
    assign full        = (cnt == FULL);
    assign can_send[v] = (cnt != '0);
    assign ovf[v]      = inc & ~dec & full;

    always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= FULL;
      else if (dec && !inc)      cnt <= cnt - 1'b1;
      else if (inc && !dec && !full) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/vc_credit_tracker_chk.sv
module vc_credit_tracker_chk #(
  parameter int NUM_VC = 4,
  parameter int VW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              send_vld,
  input logic [VW-1:0]     send_vc,
  input logic              crd_vld,
  input logic [VW-1:0]     crd_vc,
  input logic [NUM_VC-1:0] can_send,
  input logic              send_err,
  input logic              crd_err
);

  p_ovf_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crd_err |-> $past(crd_vld));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_p
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!can_send[v] && !($past(crd_vld) && $past(crd_vc) == VW'(v))) |=> !can_send[v]);

    p_credit_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(can_send[v]) |-> $past(crd_vld && crd_vc == VW'(v), 2));

    p_drain_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(can_send[v]) |-> $past(send_vld && send_vc == VW'(v)));

    p_credit_revives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!can_send[v] && $past(crd_vld) && $past(crd_vc) == VW'(v)) |=> can_send[v]);
  end

endmodule

bind vc_credit_tracker vc_credit_tracker_chk #(.NUM_VC(NUM_VC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_vc(send_vc),
  .crd_vld(crd_vld), .crd_vc(crd_vc), .can_send(can_send),
  .send_err(send_err), .crd_err(crd_err)
);

// File: tb/vc_credit_tracker_tb.sv
module vc_credit_tracker_tb;
  localparam int NUM_VC = 4;
  localparam int DEPTH  = 6;
  localparam int VW     = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic send_vld, crd_vld;
  logic [VW-1:0] send_vc, crd_vc;
  logic [NUM_VC-1:0] can_send;
  logic send_err, crd_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cnt [NUM_VC];
  bit m_pv;
  int m_pvc;
  logic obs_crd_err;

  always #2.5 clk = ~clk;

  vc_credit_tracker #(.NUM_VC(NUM_VC), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_vc(send_vc),
    .crd_vld(crd_vld), .crd_vc(crd_vc), .can_send(can_send),
    .send_err(send_err), .crd_err(crd_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_can();
    int r = 0;
    for (int v = 0; v < NUM_VC; v++) if (m_cnt[v] != 0) r |= (1 << v);
    return r;
  endfunction

  // called just after a negedge; returns just after the next negedge
  task automatic step(input bit sv, input int svc, input bit cv, input int cvc);
    bit ok, e_serr, e_cerr;
    send_vld = sv; send_vc = VW'(svc); crd_vld = cv; crd_vc = VW'(cvc);
    #1;
    ok     = sv && m_cnt[svc] != 0;
    e_serr = sv && m_cnt[svc] == 0;
    e_cerr = m_pv && m_cnt[m_pvc] == DEPTH && !(ok && svc == m_pvc);
    chk("R2 R5 R6 R8 can_send", int'(can_send), exp_can());
    chk("R3 send_err", int'(send_err), int'(e_serr));
    chk("R7 crd_err", int'(crd_err), int'(e_cerr));
    obs_crd_err = crd_err;
    @(posedge clk);
    for (int v = 0; v < NUM_VC; v++) begin
      bit inc = m_pv && m_pvc == v;
      bit dec = ok && svc == v;
      if (inc && !dec && m_cnt[v] < DEPTH) m_cnt[v]++;
      else if (dec && !inc) m_cnt[v]--;
    end
    m_pv = cv; m_pvc = cvc;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; send_vld = 0; crd_vld = 0; send_vc = '0; crd_vc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NUM_VC; v++) m_cnt[v] = DEPTH;
    m_pv = 0; m_pvc = 0;
    #1;
    chk("R1 can_send after reset", int'(can_send), (1 << NUM_VC) - 1);
    chk("R1 send_err after reset", int'(send_err), 0);
    chk("R1 crd_err after reset", int'(crd_err), 0);

    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0);
    chk("R9 vc0 open after five launches", int'(can_send[0]), 1);
    step(1, 0, 0, 0);
    chk("R9 R3 vc0 blocked after six", int'(can_send[0]), 0);
    chk("R8 vc1 still open", int'(can_send[1]), 1);
    step(1, 0, 0, 0);
    chk("R3 no wrap after zero launch", int'(can_send[0]), 0);

    step(0, 0, 1, 0);
    chk("R4 credit not yet applied", int'(can_send[0]), 0);
    step(0, 0, 0, 0);
    chk("R4 R5 credit applied", int'(can_send[0]), 1);

    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R6 coincident send and credit", int'(can_send[0]), 1);
    step(1, 0, 0, 0);
    chk("R6 count was one", int'(can_send[0]), 0);

    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    chk("R7 overflow flagged", int'(obs_crd_err), 1);
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0);
    chk("R7 saturated at depth", int'(can_send[1]), 0);

    for (int i = 0; i < 4000; i++) begin
      bit sv = ($urandom % 4) != 0;
      bit cv = ($urandom % 3) != 0;
      step(sv, int'($urandom % NUM_VC), cv, int'($urandom % NUM_VC));
    end
    step(0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule